// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the half-duplex, clocked shift-register mode of a byte-oriented serial port. It has two pins. The first is a shift clock that the block always drives. The second is a data pin that the block drives while it transmits and samples while it receives. Software sees two byte-wide locations on a simple register port. Location 0 holds the control and flag bits. Location 1 is the data buffer: a write there starts a transmission, and a read returns the last byte received.

Timing is set by a phase input, `osc_phase`, which counts the oscillator periods inside one machine cycle (0 up to `PHASES-1`). Each bit takes exactly one machine cycle. The outgoing bit changes at the start of phase 0. The shift clock is low during phases 4 to 9 and rises at the start of phase 10. Incoming data is taken at that rising edge, so the value present during phase 9 is the one stored.

The state machine has five states:
- `ST_IDLE`: the block is waiting.
- `ST_TX_ALIGN`: a transmission is waiting for a cycle boundary.
- `ST_TX_SHIFT`: the block is sending.
- `ST_RX_ALIGN`: a reception is waiting for a cycle boundary.
- `ST_RX_SHIFT`: the block is receiving.

The transitions are:
- `ST_IDLE` → `ST_TX_ALIGN` on a buffer write.
- `ST_IDLE` → `ST_RX_ALIGN` when receive is enabled and the receive flag is clear. A buffer write takes precedence over this transition.
- Each align state moves to its shift state at the end of phase `PHASES-1`.
- Each shift state returns to `ST_IDLE` at the end of phase `PHASES-1` in the eighth bit cycle.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, the control register reads 00h and the receive buffer reads 00h. `sclk` is 1, `data_oe` is 0 and `data_out` is 1.
- R2: Control register fields, at location 0 (`rd_addr`/`wr_addr` = 0): bits 7:6 mode, bit 5 multiprocessor, bit 4 receive enable, bit 3 ninth transmit bit, bit 2 ninth receive bit, bit 1 transmit-done flag, bit 0 receive-done flag. A write stores every bit, and the stored byte reads back unchanged.
- R3: A write to location 1 while idle sends the byte least significant bit first. Bit k is on `data_out`, with `data_oe` at 1, for all of the k-th machine cycle. That cycle starts at the first phase 0 after the write, provided the write is not taken in the last phase.
- R4: During a transfer, `sclk` has a period of `PHASES` clocks. It is 0 in phases 4 to 9 and 1 otherwise, and a transfer has exactly 8 low pulses. Between transfers `sclk` stays at 1.
- R5: `data_out` changes only at the start of phase 0, so each bit is stable for 10 oscillator periods before the rising edge of `sclk`.
- R6: The transmit-done flag (bit 1) becomes 1 in the phase 0 that follows the eighth bit cycle. `data_oe` returns to 0 in that same phase.
- R7: A write to location 1 during a transfer is ignored: the bit stream does not change and no further transfer follows.
- R8: While receiving, `data_oe` is 0. The value of `data_in` during phase 9 of each bit cycle is stored, least significant bit first. A value that changes from phase 10 onwards has no effect.
- R9: After 8 received bits, the receive-done flag (bit 0) is 1 in the next phase 0, and location 1 reads the received byte. No new reception starts while the flag stays 1. Clearing it with receive enable still set starts the next reception.
- R10: Reception starts from idle only when receive enable is 1 and the receive-done flag is 0. With receive enable at 0, `sclk` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_phase | input | $clog2(PHASES) | Oscillator period within the machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write location: 0 control, 1 data buffer |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read location: 0 control, 1 receive buffer |
| rd_data | output | DATA_W | Read data, combinational |
| sclk | output | 1 | Shift clock |
| data_out | output | 1 | Serial data driven to the pin |
| data_oe | output | 1 | Output enable for the data pin |
| data_in | input | 1 | Serial data sampled from the pin |

## Verification
The hardest situations to reach are a buffer write that lands in the middle of a running transmission, and a change of `data_in` just after the sampling edge. The bench triggers both from inside its per-cycle checking loop, at known phases. For the first, it injects the inverted byte during phase 6 of the fourth bit. For the second, it inverts the line in phases 10 and 11 of every received bit, so a design that samples late picks up wrong bits. The bench also holds the receive-done flag at 1 and watches the clock stay idle, then clears the flag to show that reception resumes.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_ALIGN,
        ST_TX_SHIFT,
        ST_RX_ALIGN,
        ST_RX_SHIFT
    } ssp_state_t;

    // control register bit positions (decoded by software)
    localparam int unsigned CTL_RX_DONE = 0;
    localparam int unsigned CTL_TX_DONE = 1;
    localparam int unsigned CTL_RX9     = 2;
    localparam int unsigned CTL_TX9     = 3;
    localparam int unsigned CTL_RX_EN   = 4;
    localparam int unsigned CTL_MPC     = 5;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_BUF = 1'b1;

endpackage

// File: rtl/ssp_phase_decode.sv
module ssp_phase_decode #(
    parameter int unsigned PHASES  = 12,
    parameter int unsigned FALL_AT = 3,
    parameter int unsigned RISE_AT = 9,
    localparam int unsigned PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] osc_phase,
    output logic          fall_stb,
    output logic          rise_stb,
    output logic          last_stb
);

    always_comb begin
        fall_stb = (osc_phase == PW'(FALL_AT));
        rise_stb = (osc_phase == PW'(RISE_AT));
        last_stb = (osc_phase == PW'(PHASES - 1));
    end

    // phase input must stay inside one machine cycle
    assert_phase_range_R4: assert property (@(posedge clk) disable iff (rst)
        osc_phase < PW'(PHASES));

endmodule

// File: rtl/ssp_ctrl_regs.sv
module ssp_ctrl_regs
    import ssp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         set_tx_done,
    input  logic         set_rx_done,
    input  logic [W-1:0] rx_byte,
    output logic         rx_en,
    output logic         rx_done,
    output logic         buf_wr
);

    logic [W-1:0] ctl_q, ctl_d, rxb_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && wr_addr == ADDR_CTL) ctl_d = wr_data;
        // hardware setting of a flag wins over a software clear
        if (set_tx_done) ctl_d[CTL_TX_DONE] = 1'b1;
        if (set_rx_done) ctl_d[CTL_RX_DONE] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            rxb_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (set_rx_done) rxb_q <= rx_byte;
        end
    end

    always_comb begin
        rx_en   = ctl_q[CTL_RX_EN];
        rx_done = ctl_q[CTL_RX_DONE];
        buf_wr  = wr_en && (wr_addr == ADDR_BUF);
        rd_data = (rd_addr == ADDR_BUF) ? rxb_q : ctl_q;
    end

    assert_tx_flag_R6: assert property (@(posedge clk) disable iff (rst)
        set_tx_done |=> ctl_q[CTL_TX_DONE]);

    assert_rx_flag_R9: assert property (@(posedge clk) disable iff (rst)
        set_rx_done |=> (ctl_q[CTL_RX_DONE] && rxb_q == $past(rx_byte)));

endmodule

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine
    import ssp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fall_stb,
    input  logic         rise_stb,
    input  logic         last_stb,
    input  logic         start_tx,
    input  logic [W-1:0] tx_byte,
    input  logic         rx_ok,
    input  logic         data_in,
    output logic         sclk,
    output logic         data_out,
    output logic         data_oe,
    output logic         set_tx_done,
    output logic         set_rx_done,
    output logic [W-1:0] rx_byte
);

    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);

    ssp_state_t    state_q, state_d;
    logic [W-1:0]  tx_sr, rx_sr;
    logic [CW-1:0] cnt_q;
    logic          bits_done;

    assign bits_done = (cnt_q == CNT_FULL);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and completion pulses
    always_comb begin
        state_d     = state_q;
        set_tx_done = 1'b0;
        set_rx_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_tx)   state_d = ST_TX_ALIGN;
                else if (rx_ok) state_d = ST_RX_ALIGN;
            end
            ST_TX_ALIGN: if (last_stb) state_d = ST_TX_SHIFT;
            ST_TX_SHIFT: if (last_stb && bits_done) begin
                state_d     = ST_IDLE;
                set_tx_done = 1'b1;
            end
            ST_RX_ALIGN: if (last_stb) state_d = ST_RX_SHIFT;
            ST_RX_SHIFT: if (last_stb && bits_done) begin
                state_d     = ST_IDLE;
                set_rx_done = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs and shift paths
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk     <= 1'b1;
            data_out <= 1'b1;
            data_oe  <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            cnt_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk     <= 1'b1;
                    data_out <= 1'b1;
                    data_oe  <= 1'b0;
                    cnt_q    <= '0;
                    if (start_tx) tx_sr <= tx_byte;
                end
                ST_TX_ALIGN: begin
                    if (last_stb) begin
                        data_out <= tx_sr[0];
                        data_oe  <= 1'b1;
                        tx_sr    <= tx_sr >> 1;
                    end
                end
                ST_TX_SHIFT: begin
                    if (fall_stb) sclk <= 1'b0;
                    if (rise_stb) begin
                        sclk  <= 1'b1;
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (last_stb) begin
                        if (bits_done) begin
                            data_out <= 1'b1;
                            data_oe  <= 1'b0;
                            cnt_q    <= '0;
                        end else begin
                            data_out <= tx_sr[0];
                            tx_sr    <= tx_sr >> 1;
                        end
                    end
                end
                ST_RX_ALIGN: begin
                    cnt_q <= '0;
                end
                ST_RX_SHIFT: begin
                    if (fall_stb) sclk <= 1'b0;
                    if (rise_stb) begin
                        sclk  <= 1'b1;
                        cnt_q <= cnt_q + 1'b1;
                        rx_sr <= {data_in, rx_sr[W-1:1]};
                    end
                    if (last_stb && bits_done) cnt_q <= '0;
                end
                default: begin
                    sclk    <= 1'b1;
                    data_oe <= 1'b0;
                end
            endcase
        end
    end

    assign rx_byte = rx_sr;

    assert_sclk_edges_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> $past(fall_stb || rise_stb));

    assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> sclk);

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);

    assert_oe_tx_only_R3: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (state_q == ST_TX_SHIFT));

    assert_data_setup_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_out) |-> $past(last_stb));

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (start_tx && state_q == ST_TX_SHIFT && !last_stb) |=> (tx_sr == $past(tx_sr)));

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned PHASES  = 12,
    parameter int unsigned FALL_AT = 3,
    parameter int unsigned RISE_AT = 9,
    localparam int unsigned PW     = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PW-1:0]     osc_phase,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              data_out,
    output logic              data_oe,
    input  logic              data_in
);

    logic fall_stb, rise_stb, last_stb;
    logic set_tx_done, set_rx_done;
    logic rx_en, rx_done, buf_wr;
    logic [DATA_W-1:0] rx_byte;

    ssp_phase_decode #(
        .PHASES (PHASES),
        .FALL_AT(FALL_AT),
        .RISE_AT(RISE_AT)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .osc_phase(osc_phase),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .last_stb (last_stb)
    );

    ssp_ctrl_regs #(.W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .set_tx_done(set_tx_done),
        .set_rx_done(set_rx_done),
        .rx_byte    (rx_byte),
        .rx_en      (rx_en),
        .rx_done    (rx_done),
        .buf_wr     (buf_wr)
    );

    ssp_shift_engine #(.W(DATA_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .fall_stb   (fall_stb),
        .rise_stb   (rise_stb),
        .last_stb   (last_stb),
        .start_tx   (buf_wr),
        .tx_byte    (wr_data),
        .rx_ok      (rx_en && !rx_done),
        .data_in    (data_in),
        .sclk       (sclk),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .set_tx_done(set_tx_done),
        .set_rx_done(set_rx_done),
        .rx_byte    (rx_byte)
    );

endmodule

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] osc_phase = '0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       sclk, data_out, data_oe;
    logic       data_in = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    sync_shift_port dut (
        .clk(clk), .rst(rst), .osc_phase(osc_phase),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk(sclk), .data_out(data_out), .data_oe(data_oe), .data_in(data_in)
    );

    always #10 clk = ~clk;

    always @(posedge clk) osc_phase <= (osc_phase == 4'd11) ? 4'd0 : osc_phase + 4'd1;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (phase %0d)", req, act, exp, osc_phase);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
        rd_addr = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic to_phase(input int p);
        while (osc_phase != 4'(p)) @(negedge clk);
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, {30'd0, sclk, data_oe}, 32'h2);
            @(negedge clk);
        end
    endtask

    // expected shift clock: low in phases 4..9
    function automatic logic exp_sclk(input int c);
        return !(c >= 4 && c <= 9);
    endfunction

    task automatic tx_byte(input logic [7:0] b, input bit inject);
        logic [7:0] v;
        wr(1'b0, 8'h00);
        to_phase(5);
        wr(1'b1, b);
        to_phase(0);
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 12; c++) begin
                chk(c == 0 ? "R3 data bit" : "R5 data held", {31'd0, data_out}, {31'd0, b[k]});
                chk("R3 oe", {31'd0, data_oe}, 32'd1);
                chk(inject ? "R7 sclk" : "R4 sclk", {31'd0, sclk}, {31'd0, exp_sclk(c)});
                if (k == 7 && c == 11) begin
                    rd(1'b0, v);
                    chk("R6 flag not early", {24'd0, v}, 32'h00);
                end
                if (inject && k == 3 && c == 6) begin
                    wr_en = 1'b1; wr_addr = 1'b1; wr_data = ~b;
                end else begin
                    wr_en = 1'b0;
                end
                @(negedge clk);
            end
        end
        rd(1'b0, v);
        chk("R6 tx flag", {24'd0, v}, 32'h02);
        chk("R6 oe release", {30'd0, sclk, data_oe}, 32'h2);
        quiet(inject ? "R7 no extra" : "R4 idle", 30);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        logic [7:0] v;
        to_phase(5);
        wr(1'b0, 8'h10);
        to_phase(0);
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 12; c++) begin
                chk("R8 oe off", {31'd0, data_oe}, 32'd0);
                chk("R4 rx sclk", {31'd0, sclk}, {31'd0, exp_sclk(c)});
                data_in = (c <= 9) ? b[k] : ~b[k];
                @(negedge clk);
            end
        end
        data_in = 1'b1;
        rd(1'b0, v);
        chk("R9 rx flag", {24'd0, v}, 32'h11);
        rd(1'b1, v);
        chk("R8 rx byte", {24'd0, v}, {24'd0, b});
        quiet("R9 hold while flag", 30);
    endtask

    logic [7:0] pat [0:12];

    initial begin
        logic [7:0] v;
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h5A; pat[4] = 8'h3C;
        for (int i = 0; i < 8; i++) pat[5 + i] = 8'(1 << i);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(1'b0, v); chk("R1 ctl reset", {24'd0, v}, 32'h00);
        rd(1'b1, v); chk("R1 buf reset", {24'd0, v}, 32'h00);
        chk("R1 pins", {29'd0, sclk, data_oe, data_out}, 32'h5);

        wr(1'b0, 8'hEC);
        rd(1'b0, v); chk("R2 ctl readback", {24'd0, v}, 32'hEC);
        quiet("R10 no rx without enable", 30);
        wr(1'b0, 8'h03);
        rd(1'b0, v); chk("R2 flags writable", {24'd0, v}, 32'h03);
        wr(1'b0, 8'h13);
        quiet("R10 no rx while flag set", 30);
        wr(1'b0, 8'h00);

        for (int i = 0; i < 13; i++) tx_byte(pat[i], 1'b0);
        tx_byte(8'hC6, 1'b1);
        tx_byte(8'h01, 1'b1);

        for (int i = 0; i < 13; i++) rx_byte(pat[i]);
        wr(1'b0, 8'h00);
        quiet("R10 idle after disable", 30);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule